// File: doc/BRIEF.md
# Phase-Preserving Rollover Interval Timer

An 8-bit up-counter that advances on a selectable tick and flags a pending interrupt whenever an advance takes it from 255 back to 0. The tick is either every core clock cycle or a chosen edge of an external count pin. Either kind of tick can be divided down by a power-of-two prescaler, or the prescaler can be bypassed.

Software has two ways to move the count. A clear strobe zeroes it. An adjust strobe adds a signed 8-bit operand to the live value. The adjust is meant for the end of a service routine. Adding the negative of the period keeps the cycles already spent in the routine, so the next rollover stays on the original grid.

Nothing else touches the count. The pending flag can always be read, even while the request is masked, so software can poll for a rollover that happened during a service routine.

Top module: `phase_interval_timer`

## Requirements
- R1: Each advance adds 1 to `count`, modulo 256. An advance from 255 to 0 sets `pend` on the same clock edge.
- R2: `clr_stb` sets `count` to 0 and restarts the prescaler. It takes precedence over `adj_stb` and over any advance in that cycle.
- R3: `adj_stb` (without `clr_stb`) replaces the count with `count + adj_val`, where `adj_val` is two's complement. It also restarts the prescaler and drops any advance in that cycle.
  - For example, a count of 50 adjusted by -100 becomes 206, and rolls over 50 advances later.
  - A wrap caused by an adjust does not set `pend`.
- R4: With `ctrl[3]`=1 every tick is an advance. With `ctrl[3]`=0, `ctrl[6:4]`=n selects one advance per 2^(n+1) ticks, from 1:2 (n=0) to 1:256 (n=7).
- R5: `ctrl[0]`=0 makes every clock cycle a tick. `ctrl[0]`=1 makes a tick from each selected edge of `ext_pin`, which is synchronised by two flip-flops. A level present before clock edge k shows in `count` after edge k+2.
- R6: `ctrl[1]` selects the external edge: 0 for low-to-high, 1 for high-to-low.
- R7: `irq_req` equals `pend` when `ctrl[2]`=0 and is 0 when `ctrl[2]`=1. `pend` is set by a rollover regardless of `ctrl[2]`.
- R8: `irq_ack` clears `pend`. If a rollover occurs in the same cycle, `pend` ends up set.
- R9: After reset, `count`, `pend` and the prescaler are 0. Without a clear, an adjust or an advance, `count` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one cycle is one internal tick |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | 1 | External count input, asynchronous |
| ctrl | input | 8 | [0] source, [1] edge, [2] mask, [3] prescaler bypass, [6:4] divide select, [7] unused |
| clr_stb | input | 1 | Zero the count |
| adj_stb | input | 1 | Add `adj_val` to the count |
| adj_val | input | 8 | Signed adjust operand |
| irq_ack | input | 1 | Clear the pending flag |
| count | output | 8 | Current count |
| pend | output | 1 | Rollover pending flag |
| irq_req | output | 1 | Unmasked interrupt request |

## Verification
The bench builds the timer with its default widths: an 8-bit count and a 3-bit divide select. With these widths the full 1:2 to 1:256 divide range is reachable, and so are the 255-to-0 wrap and signed adjusts across the wrap, all within a short run. Random control bytes, pin activity and strobes are compared each cycle against a bench model. Directed sequences cover the 50 minus 100 phase case, the same-cycle set and acknowledge case, and the pin latency.

// File: rtl/phase_interval_timer.sv
module phase_interval_timer #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pin,
  input  logic [7:0]       ctrl,
  input  logic             clr_stb,
  input  logic             adj_stb,
  input  logic [CNT_W-1:0] adj_val,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] count,
  output logic             pend,
  output logic             irq_req
);
  localparam int PRE_W   = 1 << SEL_W;
  localparam int SEL_MAX = PRE_W - 1;

  logic [2:0]       pin_sync;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  wire src_ext  = ctrl[0];
  wire fall_sel = ctrl[1];
  wire masked   = ctrl[2];
  wire bypass   = ctrl[3];
  wire [SEL_W-1:0] div_sel = ctrl[4 +: SEL_W];

  wire rise_det = pin_sync[1] & ~pin_sync[2];
  wire fall_det = ~pin_sync[1] & pin_sync[2];
  wire tick     = src_ext ? (fall_sel ? fall_det : rise_det) : 1'b1;

  wire [PRE_W-1:0] div_mask = {PRE_W{1'b1}} >> (SEL_MAX - int'(div_sel));
  wire             pre_hit  = (pre_q & div_mask) == div_mask;
  wire             step     = tick & (bypass | pre_hit);
  wire             load     = clr_stb | adj_stb;
  wire             roll     = step & ~load & (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_sync <= '0;
    else        pin_sync <= {pin_sync[1:0], ext_pin};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pre_q <= '0;
    else if (load)             pre_q <= '0;
    else if (tick && !bypass)  pre_q <= pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt_q <= '0;
    else if (clr_stb) cnt_q <= '0;
    else if (adj_stb) cnt_q <= cnt_q + adj_val;
    else if (step)    cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pend_q <= 1'b0;
    else if (roll)    pend_q <= 1'b1;
    else if (irq_ack) pend_q <= 1'b0;

  assign count   = cnt_q;
  assign pend    = pend_q;
  assign irq_req = pend_q & ~masked;

  a_r1_wrap_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {CNT_W{1'b1}} && step && !load) |=> (cnt_q == '0 && pend_q));

  a_r2_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> (cnt_q == '0 && pre_q == '0));

  a_r3_adjust_adds: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_stb && !clr_stb) |=> (cnt_q == CNT_W'($past(cnt_q) + $past(adj_val))));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !roll) |=> !pend_q);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cnt_q));

  a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
    masked |-> !irq_req);
endmodule

// File: tb/phase_interval_timer_bench.sv
module phase_interval_timer_bench;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin = 1'b0;
  logic [7:0] ctrl = 8'h08;
  logic       clr_stb = 1'b0, adj_stb = 1'b0, irq_ack = 1'b0;
  logic [7:0] adj_val = 8'h00;
  logic [7:0] count;
  logic       pend, irq_req;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_cnt = 0, m_pre = 0;
  logic       m_pend = 0, m1 = 0, m2 = 0, m3 = 0;

  always #(CLK_NS/2) clk = ~clk;

  phase_interval_timer u_phase_interval_timer (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ctrl(ctrl),
    .clr_stb(clr_stb), .adj_stb(adj_stb), .adj_val(adj_val),
    .irq_ack(irq_ack), .count(count), .pend(pend), .irq_req(irq_req)
  );

  function automatic int ratio_of(input logic [2:0] n);
    return 2 << n;
  endfunction

  task automatic model_edge();
    logic tick, step, roll, edge_hit;
    edge_hit = ctrl[1] ? (!m2 && m3) : (m2 && !m3);
    tick = ctrl[0] ? edge_hit : 1'b1;
    step = tick && (ctrl[3] || (int'(m_pre) % ratio_of(ctrl[6:4]) == ratio_of(ctrl[6:4]) - 1));
    roll = 1'b0;
    m3 = m2; m2 = m1; m1 = ext_pin;
    if (clr_stb) begin m_cnt = 0; m_pre = 0; end
    else if (adj_stb) begin m_cnt = m_cnt + adj_val; m_pre = 0; end
    else begin
      if (tick && !ctrl[3]) m_pre = m_pre + 1;
      if (step) begin roll = (m_cnt == 8'hFF); m_cnt = m_cnt + 1; end
    end
    if (roll) m_pend = 1'b1;
    else if (irq_ack) m_pend = 1'b0;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    check({tag, " count"}, count, m_cnt);
    check({tag, " pend"}, pend, m_pend);
    check({tag, " irq_req (R7)"}, irq_req, m_pend && !ctrl[2]);
    clr_stb = 0; adj_stb = 0; irq_ack = 0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    #(CLK_NS * 3);
    @(negedge clk);
    check("R9 reset count", count, 0);
    check("R9 reset pend", pend, 0);
    rst_n = 1'b1;

    // R3 phase case: 50 - 100 = 206, rollover 50 advances later
    ctrl = 8'h08;
    clr_stb = 1; cyc("R2 clear");
    check("R2 cleared", count, 0);
    adj_stb = 1; adj_val = 8'd50; cyc("R3 adjust +50");
    adj_stb = 1; adj_val = 8'(-100); cyc("R3 adjust -100");
    check("R3 50-100 gives 206", count, 206);
    for (int i = 0; i < 49; i++) cyc("R1 run");
    check("R1 at 255", count, 255);
    check("R1 no pend yet", pend, 0);
    cyc("R1 wrap");
    check("R1 wrapped to 0", count, 0);
    check("R1 pend set", pend, 1);
    check("R7 irq_req unmasked", irq_req, 1);
    irq_ack = 1; cyc("R8 ack");
    check("R8 ack clears", pend, 0);

    // R8 set wins over ack
    clr_stb = 1; cyc("R2 clear");
    adj_stb = 1; adj_val = 8'hFF; cyc("R3 adjust -1");
    check("R3 adjust wrap no pend", pend, 0);
    ctrl = 8'h0C; irq_ack = 1; cyc("R8 set+ack");
    check("R8 set beats ack", pend, 1);
    check("R7 masked request", irq_req, 0);

    // R4 prescaler 1:4
    ctrl = 8'h10; clr_stb = 1; cyc("R4 clear");
    for (int i = 0; i < 8; i++) cyc("R4 div4");
    check("R4 eight clocks at 1:4", count, 2);

    // R5 external rising edge latency
    ctrl = 8'h09; ext_pin = 0; clr_stb = 1; cyc("R5 clear");
    for (int i = 0; i < 3; i++) cyc("R5 low");
    ext_pin = 1; cyc("R5 edge k"); cyc("R5 edge k+1");
    check("R5 not yet", count, 0);
    cyc("R5 edge k+2");
    check("R5 counted rise", count, 1);
    // R6 falling select ignores rise
    ctrl = 8'h0B; for (int i = 0; i < 3; i++) cyc("R6 hold");
    ext_pin = 0; for (int i = 0; i < 2; i++) cyc("R6 wait");
    check("R6 fall pending", count, 1);
    cyc("R6 fall");
    check("R6 counted fall", count, 2);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (i % 64 == 0) ctrl = 8'($urandom) & 8'h7F;
      ext_pin = 1'($urandom);
      clr_stb = ($urandom % 40) == 0;
      adj_stb = ($urandom % 16) == 0;
      adj_val = 8'($urandom);
      irq_ack = ($urandom % 8) == 0;
      cyc("R1-random R4 R5 R6 R9");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule